// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver

The block moves bytes over a three-wire synchronous link: a shift clock, a transmit line and a receive line. It has one transmit path and one receive path. Each path has its own shift register and its own single-byte buffer. Both paths share one shift clock. That clock is either made on chip by a programmable divider or taken from an external clock pin. A single control byte holds three enables and a set of mode bits. The enables are a global pin enable, a transmit enable and a receive enable. The mode bits are clock source, divider setting and bit order. Four flags report the state of the buffers and of the transfer.

Most of the design concerns what happens when the enables are cleared. The two directions behave differently.

- Clearing the transmit enable stops the transmitter and resets it. Whether its shift register is wiped depends on the clock source and on the external clock level.
- Clearing the receive enable, or the global enable, resets the receiver.
- Clearing the global enable only releases the pins. The transmitter keeps shifting internally.

The mode bits can be changed only while both direction enables are off.

Top module: `ssx_xcvr`

## Requirements
- R1: After reset, `txd_o`=1, `sclk_o`=1, both output enables are 0, all four flags are 0, and `rx_data`=0.
- R2: The control byte layout is:
  - bit 0: external clock select
  - bits 3:1: divider value D
  - bit 4: transmit enable
  - bit 5: receive enable
  - bit 6: MSB-first order
  - bit 7: global enable

  With the internal clock, `sclk_o` idles high. During a transfer each phase of `sclk_o` lasts D+1 clock cycles. TxD changes on the falling edges of the shift clock and RxD is sampled on the rising edges. A received byte appears on `rx_data` with `rx_full` set.
- R3: When bit 6 is 0, the byte is sent and assembled least significant bit first. When bit 6 is 1, the order is most significant bit first.
- R4: Writing a control byte that turns transmit on from off sets `tx_empty` and `tx_done`.
  - A `tx_we` pulse is accepted only while transmit is enabled and `tx_empty`=1. Otherwise it is ignored.
  - An accepted write clears `tx_empty`. The byte moves to the idle shift register on the next cycle, which sets `tx_empty` again and clears `tx_done`.
  - `tx_done` sets after the eighth bit only if no byte is waiting.
- R5: When a byte completes while `rx_full` is still set and no `rx_ack` comes in that cycle, `rx_overrun` is set and the new byte replaces the old one. If `rx_ack` falls in that same cycle, the new byte is stored, `rx_full` stays 1 and no overrun is flagged.
- R6: Any control write with bit 4 = 0 has these effects:
  - `tx_empty` and `tx_done` clear.
  - Any transfer in progress is abandoned.
  - The waiting byte is dropped.
  - The internal shift clock returns high and stays there.
- R7: On that transmit disable, the transmit shift register and the TxD output stage are cleared to 0 only if the external clock is selected and the synchronized clock pin is high. In every other case they keep their contents, so TxD holds its last bit.
- R8: Clearing bit 7 drops `txd_oe` and `sclk_oe`. It does not stop a running transmission: the transfer still completes and `tx_done` rises.
- R9: Any control write with bit 5 = 0 or bit 7 = 0 has these effects:
  - `rx_full` and `rx_overrun` clear.
  - Partially received bits are discarded.
  - The next byte is received from its first bit.
- R10: Bits 0-3 and 6 take the written value only if transmit and receive were both disabled before the write. The same write may also set the enables.
- R11: With the external clock selected, `sclk_oe` is 0. Shifting then follows the edges of `sclk_i` after a two-stage synchronizer. TxD updates on the falling edges and RxD is captured on the rising edges.
- R12: `rx_ack` clears `rx_full` in the next cycle unless a new byte completes in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Control byte write strobe |
| ctrl_wdata | input | 8 | Control byte (layout in R2) |
| tx_we | input | 1 | Transmit buffer write strobe |
| tx_wdata | input | DATA_W | Byte to transmit |
| rx_ack | input | 1 | Receive buffer read acknowledge |
| sclk_i | input | 1 | External shift clock pin |
| rxd_i | input | 1 | Serial receive data |
| sclk_o | output | 1 | Internally generated shift clock |
| sclk_oe | output | 1 | Drive enable for the shift clock pin |
| txd_o | output | 1 | Serial transmit data |
| txd_oe | output | 1 | Drive enable for the transmit pin |
| rx_data | output | DATA_W | Receive buffer |
| tx_empty | output | 1 | Transmit buffer empty |
| tx_done | output | 1 | Transmit shift complete |
| rx_full | output | 1 | Receive buffer full |
| rx_overrun | output | 1 | Overrun error |

## Verification
A receive completion and a buffer acknowledge can land on the same clock edge. The bench provokes this with the external clock: it raises `sclk_i` and counts two synchronizer stages to find the edge where the eighth bit is stored, then holds `rx_ack` high exactly across that edge. The bench judges the result right after that edge. The new byte must be on `rx_data`, `rx_full` must still be set and `rx_overrun` must be clear. A plain acknowledge that follows must then clear `rx_full`.

// File: rtl/ssx_pkg.sv
package ssx_pkg;
    localparam int DATA_W = 8;
    localparam int DIV_W  = 3;

    // control byte bit positions
    localparam int CB_EXT  = 0;
    localparam int CB_DIV  = 1;
    localparam int CB_TXEN = 4;
    localparam int CB_RXEN = 5;
    localparam int CB_MSB  = 6;
    localparam int CB_SIO  = 7;

    typedef struct packed {
        logic             ext;
        logic [DIV_W-1:0] div;
        logic             msb;
    } mode_t;
endpackage

// File: rtl/ssx_clkgen.sv
module ssx_clkgen #(
    parameter int DIV_W = ssx_pkg::DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_sel,
    input  logic [DIV_W-1:0] div_sel,
    input  logic             run,
    input  logic             halt,
    input  logic             sclk_i,
    input  logic             rxd_i,
    output logic             sclk_o,
    output logic             sclk_lvl,
    output logic             rxd_s,
    output logic             rise,
    output logic             fall
);
    typedef struct packed {
        logic [2:0]       s;
        logic [1:0]       r;
        logic [DIV_W-1:0] cnt;
        logic             sclk;
    } st_t;

    st_t q, d;
    logic tick;

    always_comb begin
        d    = q;
        d.s  = {q.s[1:0], sclk_i};
        d.r  = {q.r[0], rxd_i};
        tick = run && (q.cnt == div_sel);
        if (halt || !run) begin
            d.cnt  = '0;
            d.sclk = 1'b1;
        end else if (tick) begin
            d.cnt  = '0;
            d.sclk = !q.sclk;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
        if (ext_sel) begin
            rise = q.s[1] && !q.s[2];
            fall = !q.s[1] && q.s[2];
        end else begin
            rise = tick && !halt && !q.sclk;
            fall = tick && !halt && q.sclk;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{s: '1, r: '1, cnt: '0, sclk: 1'b1};
        end else begin
            q <= d;
        end
    end

    assign sclk_o   = q.sclk;
    assign sclk_lvl = q.s[1];
    assign rxd_s    = q.r[1];
endmodule

// File: rtl/ssx_tx.sv
module ssx_tx #(
    parameter int DW = ssx_pkg::DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          en_wr,
    input  logic          dis_wr,
    input  logic          clr_sh,
    input  logic          msb,
    input  logic          rise,
    input  logic          fall,
    input  logic          load,
    input  logic [DW-1:0] ldata,
    output logic          txd,
    output logic          busy,
    output logic          tbe,
    output logic          tsc
);
    localparam int CNT_W = $clog2(DW + 1);

    typedef struct packed {
        logic [DW-1:0]    sh;
        logic [DW-1:0]    hold;
        logic             full;
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic             txd;
        logic             tbe;
        logic             tsc;
    } st_t;

    st_t  q, d;
    logic done;

    always_comb begin
        d    = q;
        done = q.busy && rise && (q.cnt == CNT_W'(DW));
        if (dis_wr) begin
            d.busy = 1'b0;
            d.cnt  = '0;
            d.full = 1'b0;
            d.tbe  = 1'b0;
            d.tsc  = 1'b0;
            if (clr_sh) begin
                d.sh  = '0;
                d.txd = 1'b0;
            end
        end else if (en_wr) begin
            d.tbe = 1'b1;
            d.tsc = 1'b1;
        end else if (en) begin
            if (q.busy && fall && (q.cnt != CNT_W'(DW))) begin
                d.txd = msb ? q.sh[DW-1] : q.sh[0];
                d.sh  = msb ? (q.sh << 1) : (q.sh >> 1);
                d.cnt = q.cnt + 1'b1;
            end
            if (done) begin
                d.busy = 1'b0;
            end
            if ((!q.busy || done) && q.full) begin
                d.sh   = q.hold;
                d.busy = 1'b1;
                d.cnt  = '0;
                d.full = 1'b0;
                d.tbe  = 1'b1;
                d.tsc  = 1'b0;
            end else if (done) begin
                d.tsc = 1'b1;
            end
            if (load && q.tbe) begin
                d.hold = ldata;
                d.full = 1'b1;
                d.tbe  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{sh: '0, hold: '0, full: 1'b0, busy: 1'b0, cnt: '0,
                   txd: 1'b1, tbe: 1'b0, tsc: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign txd  = q.txd;
    assign busy = q.busy;
    assign tbe  = q.tbe;
    assign tsc  = q.tsc;
endmodule

// File: rtl/ssx_rx.sv
module ssx_rx #(
    parameter int DW = ssx_pkg::DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic          kill,
    input  logic          msb,
    input  logic          rise,
    input  logic          rxd,
    input  logic          ack,
    output logic [DW-1:0] data,
    output logic          full,
    output logic          ovr,
    output logic          done
);
    localparam int CNT_W = $clog2(DW + 1);

    typedef struct packed {
        logic [DW-1:0]    sh;
        logic [DW-1:0]    data;
        logic [CNT_W-1:0] cnt;
        logic             full;
        logic             ovr;
    } st_t;

    st_t           q, d;
    logic [DW-1:0] nsh;

    always_comb begin
        d    = q;
        nsh  = msb ? {q.sh[DW-2:0], rxd} : {rxd, q.sh[DW-1:1]};
        done = !kill && active && rise && (q.cnt == CNT_W'(DW - 1));
        if (kill) begin
            d.sh   = '0;
            d.cnt  = '0;
            d.full = 1'b0;
            d.ovr  = 1'b0;
        end else begin
            if (ack) begin
                d.full = 1'b0;
            end
            if (done) begin
                d.data = nsh;
                d.sh   = '0;
                d.cnt  = '0;
                d.full = 1'b1;
                if (q.full && !ack) begin
                    d.ovr = 1'b1;
                end
            end else if (active && rise) begin
                d.sh  = nsh;
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{sh: '0, data: '0, cnt: '0, full: 1'b0, ovr: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign data = q.data;
    assign full = q.full;
    assign ovr  = q.ovr;
endmodule

// File: rtl/ssx_xcvr.sv
module ssx_xcvr #(
    parameter int DATA_W = ssx_pkg::DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [7:0]        ctrl_wdata,
    input  logic              tx_we,
    input  logic [DATA_W-1:0] tx_wdata,
    input  logic              rx_ack,
    input  logic              sclk_i,
    input  logic              rxd_i,
    output logic              sclk_o,
    output logic              sclk_oe,
    output logic              txd_o,
    output logic              txd_oe,
    output logic [DATA_W-1:0] rx_data,
    output logic              tx_empty,
    output logic              tx_done,
    output logic              rx_full,
    output logic              rx_overrun
);
    import ssx_pkg::*;

    typedef struct packed {
        mode_t mode;
        logic  tx_en;
        logic  rx_en;
        logic  sio_en;
    } ctl_t;

    ctl_t ctl_q, ctl_d;
    logic tx_dis_wr, tx_en_wr, rx_kill;
    logic sclk_lvl, rxd_s, sh_rise, sh_fall, tx_busy, rx_done;

    always_comb begin
        ctl_d     = ctl_q;
        tx_dis_wr = ctrl_we && !ctrl_wdata[CB_TXEN];
        tx_en_wr  = ctrl_we && ctrl_wdata[CB_TXEN] && !ctl_q.tx_en;
        rx_kill   = ctrl_we && (!ctrl_wdata[CB_RXEN] || !ctrl_wdata[CB_SIO]);
        if (ctrl_we) begin
            ctl_d.tx_en  = ctrl_wdata[CB_TXEN];
            ctl_d.rx_en  = ctrl_wdata[CB_RXEN];
            ctl_d.sio_en = ctrl_wdata[CB_SIO];
            if (!ctl_q.tx_en && !ctl_q.rx_en) begin
                ctl_d.mode.ext = ctrl_wdata[CB_EXT];
                ctl_d.mode.div = ctrl_wdata[CB_DIV +: DIV_W];
                ctl_d.mode.msb = ctrl_wdata[CB_MSB];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    ssx_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk     (clk),
        .rst_n   (rst_n),
        .ext_sel (ctl_q.mode.ext),
        .div_sel (ctl_q.mode.div),
        .run     (!ctl_q.mode.ext && tx_busy),
        .halt    (tx_dis_wr),
        .sclk_i  (sclk_i),
        .rxd_i   (rxd_i),
        .sclk_o  (sclk_o),
        .sclk_lvl(sclk_lvl),
        .rxd_s   (rxd_s),
        .rise    (sh_rise),
        .fall    (sh_fall)
    );

    ssx_tx #(.DW(DATA_W)) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (ctl_q.tx_en),
        .en_wr (tx_en_wr),
        .dis_wr(tx_dis_wr),
        .clr_sh(ctl_q.mode.ext && sclk_lvl),
        .msb   (ctl_q.mode.msb),
        .rise  (sh_rise),
        .fall  (sh_fall),
        .load  (tx_we),
        .ldata (tx_wdata),
        .txd   (txd_o),
        .busy  (tx_busy),
        .tbe   (tx_empty),
        .tsc   (tx_done)
    );

    ssx_rx #(.DW(DATA_W)) u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .active(ctl_q.rx_en && ctl_q.sio_en),
        .kill  (rx_kill),
        .msb   (ctl_q.mode.msb),
        .rise  (sh_rise),
        .rxd   (rxd_s),
        .ack   (rx_ack),
        .data  (rx_data),
        .full  (rx_full),
        .ovr   (rx_overrun),
        .done  (rx_done)
    );

    assign txd_oe  = ctl_q.sio_en;
    assign sclk_oe = ctl_q.sio_en && !ctl_q.mode.ext;
endmodule

// File: rtl/ssx_checker.sv
module ssx_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       ctrl_we,
    input logic [7:0] ctrl_wdata,
    input logic       rx_ack,
    input logic       rx_full,
    input logic       rx_overrun,
    input logic       tx_empty,
    input logic       tx_done,
    input logic       sclk_o,
    input logic       tx_busy,
    input logic       ext_sel,
    input logic       locked,
    input logic [4:0] mode_bits,
    input logic       rx_done
);
    AST_TX_OFF_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we && !ctrl_wdata[4] |=> !tx_empty && !tx_done); // R6

    AST_RX_OFF_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we && (!ctrl_wdata[5] || !ctrl_wdata[7]) |=> !rx_full && !rx_overrun); // R9

    AST_OVR_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_overrun) |-> $past(rx_full)); // R5

    AST_ACK_CLEARS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ack && !rx_done |=> !rx_full); // R12

    AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we && locked |=> $stable(mode_bits)); // R10

    AST_SCLK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy && !ext_sel |=> sclk_o); // R2
endmodule

bind ssx_xcvr ssx_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_we   (ctrl_we),
    .ctrl_wdata(ctrl_wdata),
    .rx_ack    (rx_ack),
    .rx_full   (rx_full),
    .rx_overrun(rx_overrun),
    .tx_empty  (tx_empty),
    .tx_done   (tx_done),
    .sclk_o    (sclk_o),
    .tx_busy   (tx_busy),
    .ext_sel   (ctl_q.mode.ext),
    .locked    (ctl_q.tx_en || ctl_q.rx_en),
    .mode_bits (ctl_q.mode),
    .rx_done   (rx_done)
);

// File: tb/ssx_xcvr_test.sv
module ssx_xcvr_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_we = 1'b0;
    logic [7:0] ctrl_wdata = '0;
    logic       tx_we = 1'b0;
    logic [7:0] tx_wdata = '0;
    logic       ack_mon = 1'b0;
    logic       ack_tst = 1'b0;
    logic       sclk_i = 1'b1;
    logic       rxd_drv = 1'b1;
    logic       loop = 1'b1;
    logic       mon_en = 1'b0;
    logic       sclk_o, sclk_oe, txd_o, txd_oe;
    logic [7:0] rx_data;
    logic       tx_empty, tx_done, rx_full, rx_overrun;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] exp_q[$];

    always #4 clk = !clk;

    ssx_xcvr uut (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .tx_we(tx_we), .tx_wdata(tx_wdata), .rx_ack(ack_mon | ack_tst),
        .sclk_i(sclk_i), .rxd_i(loop ? txd_o : rxd_drv),
        .sclk_o(sclk_o), .sclk_oe(sclk_oe), .txd_o(txd_o), .txd_oe(txd_oe),
        .rx_data(rx_data), .tx_empty(tx_empty), .tx_done(tx_done),
        .rx_full(rx_full), .rx_overrun(rx_overrun)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic wr_ctrl(input logic [7:0] v);
        @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
        @(negedge clk); ctrl_we = 1'b0;
    endtask

    task automatic load_byte(input logic [7:0] b, input bit push);
        if (push) exp_q.push_back(b);
        @(negedge clk); tx_we = 1'b1; tx_wdata = b;
        @(negedge clk); tx_we = 1'b0;
    endtask

    task automatic send(input logic [7:0] b);
        for (int i = 0; i < 3000 && !tx_empty; i++) @(negedge clk);
        load_byte(b, 1'b1);
    endtask

    task automatic capture(output logic [7:0] v);
        logic prev;
        v = '0;
        prev = sclk_o;
        for (int k = 0; k < 8; k++) begin
            for (int i = 0; i < 3000; i++) begin
                @(negedge clk);
                if (!prev && sclk_o) begin
                    prev = sclk_o;
                    break;
                end
                prev = sclk_o;
            end
            v[k] = txd_o;
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ext_bit(input logic b);
        rxd_drv = b; sclk_i = 1'b0; wait_n(6);
        sclk_i = 1'b1; wait_n(6);
    endtask

    task automatic wait_drain;
        for (int i = 0; i < 3000 && (exp_q.size() != 0 || !tx_done); i++) @(negedge clk);
        wait_n(4);
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (mon_en && rx_full) begin
                if (exp_q.size() == 0) begin
                    chk("R4", "unexpected byte received", {24'd0, rx_data}, 32'hFFFF);
                end else begin
                    chk("R2", "received byte", {24'd0, rx_data}, {24'd0, exp_q.pop_front()});
                end
                ack_mon = 1'b1;
                @(negedge clk);
                ack_mon = 1'b0;
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] cap;
        int lowc;
        wait_n(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "txd_o", {31'd0, txd_o}, 1);
        chk("R1", "sclk_o", {31'd0, sclk_o}, 1);
        chk("R1", "oes", {30'd0, txd_oe, sclk_oe}, 0);
        chk("R1", "flags", {28'd0, tx_empty, tx_done, rx_full, rx_overrun}, 0);
        chk("R1", "rx_data", {24'd0, rx_data}, 0);

        // internal clock, D=3, LSB first, loopback
        mon_en = 1'b1;
        wr_ctrl(8'hB6);
        chk("R4", "enable flags", {30'd0, tx_empty, tx_done}, 2'b11);
        chk("R2", "oes on", {30'd0, txd_oe, sclk_oe}, 2'b11);
        send(8'hA5);
        chk("R4", "tx_empty after accept", {31'd0, tx_empty}, 0);
        @(negedge clk);
        chk("R4", "empty/done after move", {30'd0, tx_empty, tx_done}, 2'b10);
        for (int i = 0; i < 200 && sclk_o; i++) @(negedge clk);
        lowc = 0;
        while (!sclk_o && lowc < 100) begin lowc++; @(negedge clk); end
        chk("R2", "sclk low phase", lowc, 4);
        load_byte(8'h3C, 1'b1);
        chk("R4", "tx_empty while waiting", {31'd0, tx_empty}, 0);
        load_byte(8'h77, 1'b0); // must be ignored, scoreboard flags extra byte
        chk("R4", "tx_done while busy", {31'd0, tx_done}, 0);
        wait_drain();
        chk("R4", "tx_done after last byte", {31'd0, tx_done}, 1);
        chk("R4", "queue drained", exp_q.size(), 0);

        // R10: bit order write while enabled is ignored
        wr_ctrl(8'hF6);
        fork
            send(8'h01);
            capture(cap);
        join
        chk("R10", "order unchanged while enabled", {24'd0, cap}, 32'h01);
        wait_drain();
        wr_ctrl(8'h00);
        wr_ctrl(8'hF6);
        chk("R10", "enable in same write", {30'd0, tx_empty, tx_done}, 2'b11);
        fork
            send(8'h01);
            capture(cap);
        join
        chk("R3", "MSB first on line", {24'd0, cap}, 32'h80);
        wait_drain();
        chk("R3", "MSB loopback drained", exp_q.size(), 0);

        // R5 overrun with internal clock
        mon_en = 1'b0;
        load_byte(8'h11, 1'b0);
        for (int i = 0; i < 3000 && !rx_full; i++) @(negedge clk);
        chk("R2", "first byte", {24'd0, rx_data}, 32'h11);
        load_byte(8'h22, 1'b0);
        wait_n(3);
        for (int i = 0; i < 3000 && !tx_done; i++) @(negedge clk);
        wait_n(2);
        chk("R5", "overrun set", {31'd0, rx_overrun}, 1);
        chk("R5", "buffer replaced", {24'd0, rx_data}, 32'h22);
        @(negedge clk); ack_tst = 1'b1; @(negedge clk); ack_tst = 1'b0;
        chk("R12", "ack clears full", {30'd0, rx_full, rx_overrun}, 2'b01);
        wr_ctrl(8'hD6);
        chk("R9", "rx off clears overrun", {30'd0, rx_full, rx_overrun}, 0);

        // R8 global enable off mid transfer
        wr_ctrl(8'h00);
        wr_ctrl(8'hB6);
        load_byte(8'h5A, 1'b0);
        for (int i = 0; i < 200 && sclk_o; i++) @(negedge clk);
        wr_ctrl(8'h36);
        chk("R8", "oes released", {30'd0, txd_oe, sclk_oe}, 0);
        chk("R8", "still busy", {31'd0, tx_done}, 0);
        for (int i = 0; i < 3000 && !tx_done; i++) @(negedge clk);
        chk("R8", "transfer completed", {30'd0, tx_done, tx_empty}, 2'b11);

        // R6/R7 transmit disable with internal clock keeps TxD
        wr_ctrl(8'hB6);
        load_byte(8'hFF, 1'b0);
        for (int i = 0; i < 200 && sclk_o; i++) @(negedge clk);
        wait_n(1);
        wr_ctrl(8'hA6);
        chk("R6", "flags cleared", {30'd0, tx_empty, tx_done}, 0);
        wait_n(20);
        chk("R6", "sclk parked high", {31'd0, sclk_o}, 1);
        chk("R7", "TxD kept (internal clock)", {31'd0, txd_o}, 1);

        // external clock
        wr_ctrl(8'h00);
        wr_ctrl(8'hB1);
        mon_en = 1'b1;
        chk("R11", "sclk_oe low", {31'd0, sclk_oe}, 0);
        load_byte(8'hC3, 1'b1);
        wait_n(3);
        for (int k = 0; k < 8; k++) begin
            sclk_i = 1'b0; wait_n(6);
            cap[k] = txd_o;
            sclk_i = 1'b1; wait_n(6);
        end
        chk("R11", "external clock TxD byte", {24'd0, cap}, 32'hC3);
        chk("R11", "done after 8 edges", {31'd0, tx_done}, 1);
        wait_n(4);
        chk("R11", "loopback received", exp_q.size(), 0);

        // R7: disable with SCLK low keeps, with SCLK high clears
        load_byte(8'hFF, 1'b0);
        wait_n(3);
        sclk_i = 1'b0; wait_n(6);
        wr_ctrl(8'hA1);
        chk("R7", "TxD kept with sclk low", {31'd0, txd_o}, 1);
        sclk_i = 1'b1; wait_n(6);
        wr_ctrl(8'hB1);
        load_byte(8'hFF, 1'b0);
        wait_n(3);
        sclk_i = 1'b0; wait_n(6);
        sclk_i = 1'b1; wait_n(6);
        chk("R7", "TxD before clear", {31'd0, txd_o}, 1);
        wr_ctrl(8'hA1);
        chk("R7", "TxD cleared with sclk high", {31'd0, txd_o}, 0);

        // collision of completion and acknowledge
        wr_ctrl(8'h00);
        mon_en = 1'b0;
        loop = 1'b0;
        wr_ctrl(8'hB1);
        for (int k = 0; k < 8; k++) ext_bit(1'(8'h96 >> k));
        chk("R11", "external receive", {23'd0, rx_full, rx_data}, {23'd0, 1'b1, 8'h96});
        for (int k = 0; k < 7; k++) ext_bit(1'(8'h69 >> k));
        rxd_drv = 1'b0; sclk_i = 1'b0; wait_n(6);
        sclk_i = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk); ack_tst = 1'b1;
        @(negedge clk); ack_tst = 1'b0;
        chk("R5", "collision data", {24'd0, rx_data}, 32'h69);
        chk("R5", "collision full/ovr", {30'd0, rx_full, rx_overrun}, 2'b10);
        wait_n(6);
        @(negedge clk); ack_tst = 1'b1; @(negedge clk); ack_tst = 1'b0;
        chk("R12", "plain ack", {31'd0, rx_full}, 0);

        // R9 partial bits dropped by global disable
        ext_bit(1'b1); ext_bit(1'b1); ext_bit(1'b1);
        wr_ctrl(8'h31);
        wr_ctrl(8'hB1);
        for (int k = 0; k < 8; k++) ext_bit(1'(8'h5A >> k));
        chk("R9", "clean byte after discard", {23'd0, rx_full, rx_data}, {23'd0, 1'b1, 8'h5A});

        summary();
        $finish;
    end
endmodule